// File: doc/BRIEF.md
# Snoopy MSI Cache Line Controller

This block is the coherence controller of a small direct-mapped write-back cache that shares a broadcast bus with other caches. Each line keeps a tag, a data word and one of three coherence states: Invalid, Shared (clean, possibly copied elsewhere) or Modified (dirty, the only copy, memory is stale). The core issues one load or store at a time and holds it until `core_ready` rises. Hits finish in the same cycle. Misses, and stores to Shared lines, raise `bus_req` with the command they need and wait for `bus_gnt`.

The same controller also watches every transaction that other caches put on the bus. On a snooped Read it supplies its copy of the line. On a snooped exclusive read or Upgrade it gives up its copy. If its copy is dirty, it drives the line out as a flush before it downgrades or invalidates the line. A snooped Upgrade that finds the line Modified here cannot happen in a correct system, so the controller raises an error flag.

Addresses are word addresses. The low `IDXW` bits select the line and the remaining bits form the tag. The arbiter and memory are outside the block. A snoop cycle means another master owns the bus, so the controller neither requests the bus nor completes a core access during that cycle.

Top module: `msi_line_ctrl`

## Requirements
- R1: After reset every line is Invalid: any core access misses and any snoop reports no hit.
- R2: A load that misses raises `bus_req` with command Read (code 0) and the core address. In the grant cycle the line is filled from `bus_rdata` and becomes Shared. The load then completes with that data on the next cycle.
- R3: A store to a Shared line raises `bus_req` with command Upgrade (code 2) and does not fetch data. After the grant the line is Modified and the store completes on the next cycle.
- R4: A store that misses raises command ReadExclusive (code 1). The line is filled and becomes Modified, and the store data is written on the next cycle.
- R5: A snooped Read (code 0) that hits supplies the line data on `snp_data` with `snp_hit` high. If the line is Shared, `snp_flush` stays low and the line stays Shared. If the line is Modified, `snp_flush` is high and the line becomes Shared.
- R6: A snooped ReadExclusive or Upgrade that hits invalidates the line. If the line is Modified, `snp_flush` is high in that cycle and `snp_data` carries the dirty data.
- R7: A miss whose line slot holds a Modified line first issues Flush (code 3) with the victim's address and data. After that grant it issues the fetch command for the new address.
- R8: A snooped Upgrade that hits a Modified line raises `proto_err` in that cycle.
- R9: In any cycle with `snp_valid` high, `bus_req` and `core_ready` are both low.
- R10: A load hitting a Shared or Modified line, and a store hitting a Modified line, complete in the same cycle with no bus request.
- R11: A miss whose slot holds a Shared line issues the fetch directly, with no Flush.
- R12: If a line waiting for an Upgrade grant is invalidated by a snoop, the pending store's command changes to ReadExclusive.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| core_req | input | 1 | Core access pending |
| core_we | input | 1 | 1 for store, 0 for load |
| core_addr | input | AW | Core word address |
| core_wdata | input | DW | Store data |
| core_ready | output | 1 | Access completes this cycle |
| core_rdata | output | DW | Load data, valid with core_ready |
| bus_req | output | 1 | Request to master the bus |
| bus_gnt | input | 1 | Bus granted; the command completes this cycle |
| bus_cmd | output | 2 | 0 Read, 1 ReadExclusive, 2 Upgrade, 3 Flush |
| bus_addr | output | AW | Address of the issued command |
| bus_wdata | output | DW | Write-back data for Flush |
| bus_rdata | input | DW | Fill data during a granted Read or ReadExclusive |
| snp_valid | input | 1 | Another master's transaction is on the bus |
| snp_cmd | input | 2 | Snooped command, same coding as bus_cmd |
| snp_addr | input | AW | Snooped address |
| snp_hit | output | 1 | This cache holds the snooped line |
| snp_flush | output | 1 | Dirty data driven to memory this cycle |
| snp_data | output | DW | Line data for supply or flush |
| proto_err | output | 1 | Upgrade snooped against a Modified line |

## Verification
The hardest case to reach is a store whose Upgrade is pending when another master invalidates the line. The bench holds a store to a Shared line with the grant withheld, injects a snooped ReadExclusive to the same address, and then checks that the request has turned into a ReadExclusive. Dirty evictions also need some setup. The core has to fill a slot with a store and then miss on another tag in the same slot. The bench's own memory model records each flush, and a later reload of the evicted address must return the flushed data.

// File: rtl/msi_line_ctrl.sv
module msi_line_ctrl #(
  parameter int AW   = 8,
  parameter int IDXW = 2,
  parameter int DW   = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          core_req,
  input  logic          core_we,
  input  logic [AW-1:0] core_addr,
  input  logic [DW-1:0] core_wdata,
  output logic          core_ready,
  output logic [DW-1:0] core_rdata,
  output logic          bus_req,
  input  logic          bus_gnt,
  output logic [1:0]    bus_cmd,
  output logic [AW-1:0] bus_addr,
  output logic [DW-1:0] bus_wdata,
  input  logic [DW-1:0] bus_rdata,
  input  logic          snp_valid,
  input  logic [1:0]    snp_cmd,
  input  logic [AW-1:0] snp_addr,
  output logic          snp_hit,
  output logic          snp_flush,
  output logic [DW-1:0] snp_data,
  output logic          proto_err
);
  localparam int NL = 1 << IDXW;
  localparam int TW = AW - IDXW;
  localparam logic [1:0] C_RD = 2'd0, C_RDX = 2'd1, C_UPG = 2'd2, C_FL = 2'd3;

  typedef enum logic [1:0] {ST_I = 2'd0, ST_S = 2'd1, ST_M = 2'd2} lst_t;

  lst_t          st  [NL];
  logic [TW-1:0] tg  [NL];
  logic [DW-1:0] dat [NL];

  logic [IDXW-1:0] cidx, sidx;
  logic [TW-1:0]   ctag, stag;
  logic            c_hit, victim_dirty, need_bus;

  assign cidx = core_addr[IDXW-1:0];
  assign ctag = core_addr[AW-1:IDXW];
  assign sidx = snp_addr[IDXW-1:0];
  assign stag = snp_addr[AW-1:IDXW];

  assign c_hit        = (st[cidx] != ST_I) && (tg[cidx] == ctag);
  assign victim_dirty = !c_hit && (st[cidx] == ST_M);
  assign need_bus     = !c_hit || (core_we && st[cidx] == ST_S);

  assign bus_req    = core_req && need_bus && !snp_valid;
  assign core_ready = core_req && !need_bus && !snp_valid;
  assign core_rdata = dat[cidx];

  always_comb begin
    if (victim_dirty)  bus_cmd = C_FL;
    else if (c_hit)    bus_cmd = C_UPG;
    else if (core_we)  bus_cmd = C_RDX;
    else               bus_cmd = C_RD;
  end

  assign bus_addr  = victim_dirty ? {tg[cidx], cidx} : core_addr;
  assign bus_wdata = dat[cidx];

  assign snp_hit   = snp_valid && (st[sidx] != ST_I) && (tg[sidx] == stag);
  assign snp_flush = snp_hit && (st[sidx] == ST_M) && (snp_cmd != C_FL);
  assign snp_data  = dat[sidx];
  assign proto_err = snp_hit && (st[sidx] == ST_M) && (snp_cmd == C_UPG);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NL; i++) begin
        st[i]  <= ST_I;
        tg[i]  <= '0;
        dat[i] <= '0;
      end
    end else if (snp_hit) begin
      if (snp_cmd == C_RD)       st[sidx] <= ST_S;
      else if (snp_cmd != C_FL)  st[sidx] <= ST_I;
    end else if (bus_req && bus_gnt) begin
      case (bus_cmd)
        C_FL:  st[cidx] <= ST_I;
        C_UPG: st[cidx] <= ST_M;
        C_RD: begin
          st[cidx]  <= ST_S;
          tg[cidx]  <= ctag;
          dat[cidx] <= bus_rdata;
        end
        default: begin
          st[cidx]  <= ST_M;
          tg[cidx]  <= ctag;
          dat[cidx] <= bus_rdata;
        end
      endcase
    end else if (core_ready && core_we) begin
      dat[cidx] <= core_wdata;
    end
  end
endmodule

// File: rtl/msi_line_chk.sv
module msi_line_chk #(
  parameter int AW = 8,
  parameter int DW = 16
) (
  input logic          clk,
  input logic          rst_n,
  input logic          core_req,
  input logic          core_we,
  input logic [AW-1:0] core_addr,
  input logic          core_ready,
  input logic          bus_req,
  input logic          bus_gnt,
  input logic [1:0]    bus_cmd,
  input logic [AW-1:0] bus_addr,
  input logic          snp_valid,
  input logic [1:0]    snp_cmd,
  input logic [AW-1:0] snp_addr,
  input logic          snp_hit,
  input logic          snp_flush,
  input logic          proto_err
);
  // R9
  snoop_blocks_core_chk: assert property (@(posedge clk) disable iff (!rst_n)
    snp_valid |-> (!bus_req && !core_ready));

  // R2
  fill_then_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_req && bus_gnt && bus_cmd != 2'd3) ##1
    (core_req && !snp_valid && $stable(core_addr) && $stable(core_we)) |-> core_ready);

  // R7
  flush_then_fetch_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_req && bus_gnt && bus_cmd == 2'd3) ##1
    (core_req && !snp_valid && $stable(core_addr) && $stable(core_we))
    |-> (bus_req && bus_cmd != 2'd3 && bus_addr == core_addr));

  // R6
  snoop_invalidates_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (snp_valid && snp_hit && (snp_cmd == 2'd1 || snp_cmd == 2'd2)) ##1
    (snp_valid && $stable(snp_addr)) |-> !snp_hit);

  // R5
  snoop_read_keeps_shared_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (snp_valid && snp_hit && snp_cmd == 2'd0) ##1
    (snp_valid && $stable(snp_addr) && snp_cmd == 2'd0) |-> (snp_hit && !snp_flush));

  // R8
  proto_err_flush_chk: assert property (@(posedge clk) disable iff (!rst_n)
    proto_err |-> (snp_valid && snp_cmd == 2'd2 && snp_flush));
endmodule

bind msi_line_ctrl msi_line_chk #(.AW(AW), .DW(DW)) u_chk (.*);

// File: tb/sim_msi_line_ctrl.sv
`timescale 1ns/1ps
module sim_msi_line_ctrl;
  localparam int AW = 8, IDXW = 2, DW = 16;
  localparam realtime P = 20.0;
  localparam logic [2:0] NONE = 3'd4;

  logic clk = 0, rst_n = 0;
  logic core_req = 0, core_we = 0;
  logic [AW-1:0] core_addr = '0;
  logic [DW-1:0] core_wdata = '0;
  logic core_ready;
  logic [DW-1:0] core_rdata;
  logic bus_req, bus_gnt = 0;
  logic [1:0] bus_cmd;
  logic [AW-1:0] bus_addr;
  logic [DW-1:0] bus_wdata, bus_rdata = '0;
  logic snp_valid = 0;
  logic [1:0] snp_cmd = '0;
  logic [AW-1:0] snp_addr = '0;
  logic snp_hit, snp_flush, proto_err;
  logic [DW-1:0] snp_data;

  msi_line_ctrl #(.AW(AW), .IDXW(IDXW), .DW(DW)) u0 (.*);

  always #(P/2) clk = ~clk;

  int errs = 0, checks = 0;
  bit done = 0;
  logic [DW-1:0] mem [1<<AW];

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errs++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // Drive one core access to completion with a granting bus and memory model.
  task automatic do_core(input bit we, input logic [AW-1:0] a, input logic [DW-1:0] wd,
                         output logic [2:0] first, output logic [DW-1:0] rd);
    first = NONE;
    @(negedge clk);
    core_req = 1; core_we = we; core_addr = a; core_wdata = wd;
    for (int n = 0; n < 20; n++) begin
      #1;
      if (core_ready) begin
        rd = core_rdata;
        break;
      end
      if (bus_req) begin
        if (first == NONE) first = {1'b0, bus_cmd};
        bus_gnt = 1;
        bus_rdata = mem[bus_addr];
        if (bus_cmd == 2'd3) mem[bus_addr] = bus_wdata;
      end
      @(negedge clk);
      bus_gnt = 0;
    end
    @(negedge clk);
    core_req = 0; bus_gnt = 0;
  endtask

  task automatic snoop(input logic [1:0] c, input logic [AW-1:0] a);
    @(negedge clk);
    snp_valid = 1; snp_cmd = c; snp_addr = a;
    #1;
  endtask

  // {we, addr, wdata, first command (4 none), expected load data}
  localparam logic [43:0] TBL [0:10] = '{
    {1'b0, 8'h10, 16'h0000, 3'd0, 16'h0057},  // R2 load miss
    {1'b0, 8'h10, 16'h0000, 3'd4, 16'h0057},  // R10 load hit S
    {1'b1, 8'h10, 16'hAAAA, 3'd2, 16'h0000},  // R3 upgrade
    {1'b1, 8'h10, 16'hBBBB, 3'd4, 16'h0000},  // R10 store hit M
    {1'b0, 8'h10, 16'h0000, 3'd4, 16'hBBBB},  // R10 load hit M
    {1'b0, 8'h20, 16'h0000, 3'd3, 16'h00A7},  // R7 dirty eviction
    {1'b0, 8'h10, 16'h0000, 3'd0, 16'hBBBB},  // R11 clean eviction, flushed data
    {1'b1, 8'h31, 16'h1234, 3'd1, 16'h0000},  // R4 store miss
    {1'b0, 8'h31, 16'h0000, 3'd4, 16'h1234},  // R4 line holds store data
    {1'b1, 8'h05, 16'h4444, 3'd3, 16'h0000},  // R7 dirty eviction before RdX
    {1'b0, 8'h31, 16'h0000, 3'd3, 16'h1234}   // R7 evicts 0x05 then reloads
  };

  initial begin
    #(P * 200000);
    if (!done) begin
      errs++; checks++;
      $display("FAIL watchdog actual=0 expected=1");
      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
    end
  end

  initial begin
    logic [2:0] f;
    logic [DW-1:0] rd;
    for (int i = 0; i < (1<<AW); i++) mem[i] = DW'(i * 5 + 7);
    repeat (3) @(negedge clk);
    rst_n = 1;

    // R1 reset state
    @(negedge clk);
    core_req = 1; core_we = 0; core_addr = 8'h00;
    #1;
    chk(bus_req && bus_cmd == 2'd0 && !core_ready, "R1 load after reset", {bus_req, bus_cmd}, 3'b100);
    core_req = 0;
    snoop(2'd0, 8'h00);
    chk(!snp_hit, "R1 snoop after reset", snp_hit, 0);
    snp_valid = 0;

    for (int i = 0; i < 11; i++) begin
      logic [43:0] v;
      v = TBL[i];
      do_core(v[43], v[42:35], v[34:19], f, rd);
      chk(f == v[18:16], $sformatf("R2/R3/R4/R7/R10/R11 row %0d cmd", i), f, v[18:16]);
      if (!v[43]) chk(rd == v[15:0], $sformatf("R2/R10 row %0d data", i), rd, v[15:0]);
    end
    chk(mem[8'h05] == 16'h4444, "R7 flushed data in memory", mem[8'h05], 16'h4444);

    // R5 snoop Read on Shared; R6 RdX on Shared
    snoop(2'd0, 8'h10);
    chk(snp_hit && !snp_flush && snp_data == 16'hBBBB, "R5 snoop read shared", {snp_hit, snp_flush, snp_data}, {2'b10, 16'hBBBB});
    snoop(2'd1, 8'h10);
    chk(snp_hit && !snp_flush, "R6 snoop rdx shared", {snp_hit, snp_flush}, 2'b10);
    snoop(2'd0, 8'h10);
    chk(!snp_hit, "R6 shared line invalidated", snp_hit, 0);
    snp_valid = 0;

    // R5 snoop Read on Modified
    do_core(1, 8'h22, 16'h7777, f, rd);
    snoop(2'd0, 8'h22);
    chk(snp_hit && snp_flush && snp_data == 16'h7777, "R5 snoop read modified", {snp_hit, snp_flush, snp_data}, {2'b11, 16'h7777});
    snoop(2'd0, 8'h22);
    chk(snp_hit && !snp_flush, "R5 downgraded to shared", {snp_hit, snp_flush}, 2'b10);
    snp_valid = 0;

    // R8 upgrade against Modified
    do_core(1, 8'h22, 16'h8888, f, rd);
    chk(f == 3'd2, "R3 upgrade after downgrade", f, 2);
    snoop(2'd2, 8'h22);
    chk(proto_err && snp_flush && snp_data == 16'h8888, "R8 proto error", {proto_err, snp_flush}, 2'b11);
    snoop(2'd0, 8'h22);
    chk(!snp_hit && !proto_err, "R8 line invalid after", {snp_hit, proto_err}, 0);
    snp_valid = 0;

    // R6 RdX on Modified
    do_core(1, 8'h23, 16'h9999, f, rd);
    snoop(2'd1, 8'h23);
    chk(snp_hit && snp_flush && !proto_err && snp_data == 16'h9999, "R6 snoop rdx modified", {snp_flush, snp_data}, {1'b1, 16'h9999});
    snoop(2'd0, 8'h23);
    chk(!snp_hit, "R6 modified line invalidated", snp_hit, 0);
    snp_valid = 0;

    // R9 snoop priority, hit and miss
    @(negedge clk);
    core_req = 1; core_we = 0; core_addr = 8'h31;
    snp_valid = 1; snp_cmd = 2'd0; snp_addr = 8'h77;
    #1;
    chk(!core_ready && !bus_req, "R9 hit blocked by snoop", {core_ready, bus_req}, 0);
    core_addr = 8'h42;
    #1;
    chk(!core_ready && !bus_req, "R9 miss blocked by snoop", {core_ready, bus_req}, 0);
    @(negedge clk);
    snp_valid = 0; core_req = 0;

    // R12 pending upgrade loses line
    @(negedge clk);
    core_req = 1; core_we = 1; core_addr = 8'h31; core_wdata = 16'h5555;
    #1;
    chk(bus_req && bus_cmd == 2'd2, "R12 upgrade pending", bus_cmd, 2);
    @(negedge clk);
    snp_valid = 1; snp_cmd = 2'd1; snp_addr = 8'h31;
    @(negedge clk);
    snp_valid = 0;
    #1;
    chk(bus_req && bus_cmd == 2'd1, "R12 becomes readexclusive", bus_cmd, 1);
    bus_gnt = 1; bus_rdata = 16'hDEAD;
    @(negedge clk);
    bus_gnt = 0;
    #1;
    chk(core_ready, "R12 store completes", core_ready, 1);
    @(negedge clk);
    core_req = 0;
    do_core(0, 8'h31, 16'h0, f, rd);
    chk(f == NONE && rd == 16'h5555, "R4 store data after R12 path", rd, 16'h5555);

    done = 1;
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end
endmodule